// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the control-register front end of an audio codec, seen from a simple single-cycle bus. A 64-byte window holds sixteen 32-bit direct registers, one per word offset. Behind the window sits a second bank of thirty-two 8-bit registers. Software reaches that bank indirectly: it writes a pointer into the low bits of direct register 0, then reads or writes word offset 1, which acts as a data port onto the selected byte register.

Each byte register follows its own access rule. Some are plain storage. One is write-only and always reads as zero. Two are read-only and carry fixed identification values. One keeps a single writable bit and has its other bits fixed to an identification pattern. Direct word 2 ignores writes. Direct word 4 is a control word: setting its bit 0 restores every register to its power-on value, and its low seven bits are then kept. Reads are registered, so read data appears one cycle after the read strobe. The interrupt output exists for integration but is never raised.

Top module: `ccr_codec_port`

## Requirements
- R1: After a hardware reset every direct register reads 0. Every byte register reads 0, except byte register 12, which reads 0x8A, and byte register 25, which reads 0xA0.
- R2: The word offset is bus address bits [5:2], and address bits [1:0] are ignored. A write to any word offset other than 1, 2 or 4 stores all 32 bits, and a read at any offset other than 1 returns that stored word.
- R3: The byte-register pointer is bits [4:0] of direct register 0. Direct register 0 still reads back all 32 written bits.
- R4: A read or write at word offset 1 reaches the byte register chosen by the pointer. Read data at offset 1 is that byte in bits [7:0], with bits [31:8] zero.
- R5: A read of byte register 3 through offset 1 returns 0, whatever was written there.
- R6: Writes through offset 1 to byte registers 11 and 25 leave their values unchanged.
- R7: A write to byte register 12 keeps only bit 6 of the written byte. The stored value is that bit ORed with 0x8A.
- R8: Writes to word offset 2 have no effect, and offset 2 keeps reading 0.
- R9: A write to word offset 4 with bit 0 set returns every register to its R1 value, including the pointer. Direct register 4 then holds the written value ANDed with 0x7F.
- R10: A write to word offset 4 with bit 0 clear stores the written value ANDed with 0x7F in direct register 4, and changes no other register.
- R11: Read data is updated on the clock edge that samples a read strobe, is valid from that edge onward, and holds its value until the next read strobe. It is 0 after reset.
- R12: The interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, same result as a soft reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, held low |

## Verification
Corrupt state in this block is visible at the ports on the cycle after the next read that touches it. A wrong pointer makes every later offset-1 read return a byte from another register. A broken access rule shows up as a read-only identifier that changes, a write-only register that leaks data, or register 12 losing its fixed bits. A soft reset that misses a register leaves stale data behind, and that data shows up in the next sweep over both banks. Because of this, the bench reads back both banks completely after each reset kind and after each rule-specific write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   // byte-register indices whose rules the block's behaviour depends on
   localparam int IDX_WRITE_ONLY = 3;
   localparam int IDX_LOCK_A     = 11;
   localparam int IDX_MASKED     = 12;
   localparam int IDX_LOCK_B     = 25;

   localparam logic [7:0] MASKED_FIXED = 8'h8A;
   localparam logic [7:0] MASKED_KEEP  = 8'h40;
   localparam logic [7:0] LOCK_B_VALUE = 8'hA0;

   // word offsets with special meaning
   localparam int OFF_POINTER = 0;
   localparam int OFF_WINDOW  = 1;
   localparam int OFF_SEALED  = 2;
   localparam int OFF_CONTROL = 4;

   typedef enum logic [1:0] {
      RULE_PLAIN,
      RULE_LOCKED,
      RULE_HIDDEN,
      RULE_MASKED
   } byte_rule_e;

   function automatic byte_rule_e rule_of(input int idx);
      if (idx == IDX_LOCK_A || idx == IDX_LOCK_B) return RULE_LOCKED;
      if (idx == IDX_WRITE_ONLY)                  return RULE_HIDDEN;
      if (idx == IDX_MASKED)                      return RULE_MASKED;
      return RULE_PLAIN;
   endfunction

   function automatic logic [7:0] init_of(input int idx);
      if (idx == IDX_MASKED) return MASKED_FIXED;
      if (idx == IDX_LOCK_B) return LOCK_B_VALUE;
      return 8'h00;
   endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
   parameter int ADDR_W = 6,
   localparam int OFF_W = ADDR_W - 2
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              ctl_bit,
   output logic [OFF_W-1:0]  off,
   output logic              dir_wr,
   output logic              win_wr,
   output logic              ctl_wr,
   output logic              soft_rst
);
   import ccr_pkg::*;

   logic unused_byte_lanes;
   assign unused_byte_lanes = ^bus_addr[1:0];

   assign off = bus_addr[ADDR_W-1:2];

   logic is_win, is_sealed, is_ctl;
   assign is_win    = (off == OFF_W'(OFF_WINDOW));
   assign is_sealed = (off == OFF_W'(OFF_SEALED));
   assign is_ctl    = (off == OFF_W'(OFF_CONTROL));

   assign win_wr   = bus_wr && is_win;
   assign ctl_wr   = bus_wr && is_ctl;
   assign dir_wr   = bus_wr && !is_win && !is_sealed && !is_ctl;
   assign soft_rst = ctl_wr && ctl_bit;

endmodule

// File: rtl/ccr_direct_bank.sv
module ccr_direct_bank #(
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 4,
   parameter int CTL_KEEP_W = 7,
   localparam int N_DIR     = 1 << OFF_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dir_wr,
   input  logic                           ctl_wr,
   input  logic                           soft_rst,
   input  logic [OFF_W-1:0]               off,
   input  logic [DATA_W-1:0]              wdata,
   output logic [N_DIR-1:0][DATA_W-1:0]   q
);
   import ccr_pkg::*;

   for (genvar i = 0; i < N_DIR; i++) begin : g_word
      if (i == OFF_WINDOW || i == OFF_SEALED) begin : g_void
         // never stored: offset 1 is the byte window, offset 2 is sealed
         assign q[i] = '0;
      end else if (i == OFF_CONTROL) begin : g_ctl
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      r <= '0;
            else if (ctl_wr) r <= DATA_W'(wdata[CTL_KEEP_W-1:0]);
         end
         assign q[i] = r;
      end else begin : g_plain
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               r <= '0;
            else if (soft_rst)                        r <= '0;
            else if (dir_wr && off == OFF_W'(i))      r <= wdata;
         end
         assign q[i] = r;
      end
   end

   // R10
   ctl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (q[OFF_CONTROL][DATA_W-1:CTL_KEEP_W] == '0));

   // R9
   soft_clears_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (q[OFF_POINTER] == '0));

   // R10
   ctl_leaves_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !soft_rst) |=> $stable(q[OFF_POINTER]));

endmodule

// File: rtl/ccr_byte_bank.sv
module ccr_byte_bank #(
   parameter int IND_W = 8,
   parameter int N_IND = 32,
   localparam int IDX_W = $clog2(N_IND)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          soft_rst,
   input  logic                          win_wr,
   input  logic [IDX_W-1:0]              idx,
   input  logic [IND_W-1:0]              wdata,
   output logic [N_IND-1:0][IND_W-1:0]   q
);
   import ccr_pkg::*;

   for (genvar i = 0; i < N_IND; i++) begin : g_byte
      localparam byte_rule_e RULE = rule_of(i);
      localparam logic [IND_W-1:0] INIT = IND_W'(init_of(i));
      logic hit;
      assign hit = win_wr && (idx == IDX_W'(i));

      if (RULE == RULE_LOCKED) begin : g_locked
         assign q[i] = INIT;
         logic unused_hit;
         assign unused_hit = hit;
      end else if (RULE == RULE_MASKED) begin : g_masked
         logic [IND_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        r <= INIT;
            else if (soft_rst) r <= INIT;
            else if (hit)      r <= (wdata & IND_W'(MASKED_KEEP)) | INIT;
         end
         assign q[i] = r;
      end else begin : g_plain
         // write-only registers store too; the read mux hides them
         logic [IND_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        r <= INIT;
            else if (soft_rst) r <= INIT;
            else if (hit)      r <= wdata;
         end
         assign q[i] = r;
      end
   end

   // R6
   lock_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && idx == IDX_W'(IDX_LOCK_A)) |=> $stable(q[IDX_LOCK_A]));

   // R6
   lock_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && idx == IDX_W'(IDX_LOCK_B)) |=> $stable(q[IDX_LOCK_B]));

   // R7
   masked_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr |=> ((q[IDX_MASKED] & ~IND_W'(MASKED_KEEP)) == IND_W'(MASKED_FIXED)));

   // R9
   soft_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (q[IDX_MASKED] == IND_W'(MASKED_FIXED) && q[0] == '0));

endmodule

// File: rtl/ccr_read_port.sv
module ccr_read_port #(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 4,
   parameter int IND_W  = 8,
   parameter int IDX_W  = 5,
   localparam int N_DIR = 1 << OFF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_rd,
   input  logic [OFF_W-1:0]             off,
   input  logic [IDX_W-1:0]             idx,
   input  logic [N_DIR-1:0][DATA_W-1:0] dir_q,
   input  logic [IND_W-1:0]             byte_sel,
   output logic [DATA_W-1:0]            rdata
);
   import ccr_pkg::*;

   logic [DATA_W-1:0] next_word;

   always_comb begin
      if (off == OFF_W'(OFF_WINDOW)) begin
         if (idx == IDX_W'(IDX_WRITE_ONLY)) next_word = '0;
         else                               next_word = DATA_W'(byte_sel);
      end else begin
         next_word = dir_q[off];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (bus_rd) rdata <= next_word;
   end

   // R5
   hidden_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && off == OFF_W'(OFF_WINDOW) && idx == IDX_W'(IDX_WRITE_ONLY)) |=> (rdata == '0));

   // R4
   window_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && off == OFF_W'(OFF_WINDOW)) |=> (rdata[DATA_W-1:IND_W] == '0));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(rdata));

endmodule

// File: rtl/ccr_codec_port.sv
module ccr_codec_port #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32,
   parameter int IND_W      = 8,
   parameter int N_IND      = 32,
   parameter int CTL_KEEP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import ccr_pkg::*;

   localparam int OFF_W = ADDR_W - 2;
   localparam int N_DIR = 1 << OFF_W;
   localparam int IDX_W = $clog2(N_IND);

   if (N_DIR <= OFF_CONTROL) begin : g_bad_window
      initial $fatal(1, "window too small for the control word");
   end
   if (N_IND <= IDX_LOCK_B) begin : g_bad_bytes
      initial $fatal(1, "byte bank too small for the fixed indices");
   end
   if (IND_W < 8 || DATA_W < IND_W || DATA_W <= CTL_KEEP_W || DATA_W < IDX_W) begin : g_bad_width
      initial $fatal(1, "inconsistent data widths");
   end

   logic [OFF_W-1:0]             off;
   logic                         dir_wr, win_wr, ctl_wr, soft_rst;
   logic [N_DIR-1:0][DATA_W-1:0] dir_q;
   logic [N_IND-1:0][IND_W-1:0]  byte_q;
   logic [IDX_W-1:0]             idx;
   logic [IND_W-1:0]             byte_sel;

   ccr_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .ctl_bit  (bus_wdata[0]),
      .off      (off),
      .dir_wr   (dir_wr),
      .win_wr   (win_wr),
      .ctl_wr   (ctl_wr),
      .soft_rst (soft_rst)
   );

   ccr_direct_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W), .CTL_KEEP_W(CTL_KEEP_W)) u_direct (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_wr   (dir_wr),
      .ctl_wr   (ctl_wr),
      .soft_rst (soft_rst),
      .off      (off),
      .wdata    (bus_wdata),
      .q        (dir_q)
   );

   assign idx = dir_q[OFF_POINTER][IDX_W-1:0];

   ccr_byte_bank #(.IND_W(IND_W), .N_IND(N_IND)) u_bytes (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .win_wr   (win_wr),
      .idx      (idx),
      .wdata    (bus_wdata[IND_W-1:0]),
      .q        (byte_q)
   );

   assign byte_sel = byte_q[idx];

   ccr_read_port #(.DATA_W(DATA_W), .OFF_W(OFF_W), .IND_W(IND_W), .IDX_W(IDX_W)) u_read (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rd   (bus_rd),
      .off      (off),
      .idx      (idx),
      .dir_q    (dir_q),
      .byte_sel (byte_sel),
      .rdata    (bus_rdata)
   );

   assign irq_o = 1'b0;

   // R3
   pointer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && off == OFF_W'(OFF_POINTER)) |=> (idx == $past(bus_wdata[IDX_W-1:0])));

   // R8
   sealed_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && off == OFF_W'(OFF_SEALED)) |=> (bus_rdata == '0));

endmodule

// File: tb/ccr_codec_port_tb.sv
module ccr_codec_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccr_codec_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // requirement-level model
   logic [31:0] m_dir [16];
   logic [7:0]  m_byte [32];
   logic [31:0] last_read = '0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < 16; i++) m_dir[i] = '0;
      for (int i = 0; i < 32; i++) m_byte[i] = '0;
      m_byte[12] = 8'h8A;
      m_byte[25] = 8'hA0;
   endfunction

   function automatic logic [31:0] model_read(input logic [5:0] a);
      int o = int'(a[5:2]);
      int p = int'(m_dir[0][4:0]);
      if (o == 1) return (p == 3) ? 32'h0 : {24'h0, m_byte[p]};
      return m_dir[o];
   endfunction

   function automatic void model_write(input logic [5:0] a, input logic [31:0] v);
      int o = int'(a[5:2]);
      int p = int'(m_dir[0][4:0]);
      if (o == 1) begin
         if (p == 11 || p == 25) return;
         if (p == 12) m_byte[p] = (v[7:0] & 8'h40) | 8'h8A;
         else         m_byte[p] = v[7:0];
      end else if (o == 2) begin
         return;
      end else if (o == 4) begin
         if (v[0]) model_reset();
         m_dir[4] = v & 32'h7F;
      end else begin
         m_dir[o] = v;
      end
   endfunction

   // driver
   task automatic wr(input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = v;
      model_write(a, v);
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic rd_byte(input int p, input string tag);
      wr(6'h00, 32'(p));
      rd(6'h04, tag);
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   task automatic sweep(input string tag);
      for (int o = 0; o < 16; o++) if (o != 1) rd(6'(o * 4), tag);
      for (int p = 0; p < 32; p++) rd_byte(p, tag);
      drain();
   endtask

   // monitor
   logic rd_pend = 1'b0;
   always @(posedge clk) rd_pend <= bus_rd;

   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected read data", bus_rdata, 32'hx);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_read = e;
            check(t, bus_rdata, e);
         end
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check("R11 rdata after reset", bus_rdata, 32'h0);
      check("R12 irq after reset", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;

      // R1 reset values through every register
      sweep("R1 hardware reset value");

      // R2 full-word storage, byte lanes ignored
      for (int o = 3; o < 16; o++) if (o != 4) wr(6'(o * 4), 32'hA5000000 ^ (32'(o) * 32'h01010101));
      for (int o = 3; o < 16; o++) if (o != 4) rd(6'(o * 4 + (o % 4)), "R2 direct readback");
      // R3 pointer and full direct 0
      wr(6'h00, 32'hDEADBEE7);
      rd(6'h00, "R3 direct 0 full word");
      wr(6'h04, 32'hFFFFFF5C);
      wr(6'h00, 32'h00000007);
      rd(6'h04, "R3 pointer uses low bits only");
      // R4 byte window with varied data
      for (int p = 0; p < 32; p++) begin
         wr(6'h00, 32'(p));
         wr(6'h04, 32'hFFFFFF00 | 32'((p * 37 + 11) & 8'hFF));
      end
      for (int p = 0; p < 32; p++) rd_byte(p, "R4 window readback");
      // R5 hidden register
      wr(6'h00, 32'd3); wr(6'h04, 32'h000000FF);
      rd(6'h04, "R5 write-only reads zero");
      // R6 locked identifiers
      wr(6'h00, 32'd11); wr(6'h04, 32'h0000005A);
      rd(6'h04, "R6 index 11 unchanged");
      wr(6'h00, 32'd25); wr(6'h04, 32'h00000000);
      rd(6'h04, "R6 index 25 unchanged");
      // R7 masked register
      wr(6'h00, 32'd12); wr(6'h04, 32'h000000FF);
      rd(6'h04, "R7 keep bit 6 set");
      wr(6'h04, 32'h000000BF);
      rd(6'h04, "R7 bit 6 clear");
      // R8 sealed word
      wr(6'h08, 32'h12345678);
      rd(6'h08, "R8 sealed offset");
      // R10 control without reset bit
      wr(6'h10, 32'hFFFFFFFE);
      rd(6'h10, "R10 control low bits");
      drain();
      sweep("R10 nothing else changed");
      // R11 hold between reads, across a write
      wr(6'h0C, 32'h0BADF00D);
      repeat (4) @(negedge clk);
      check("R11 rdata holds", bus_rdata, last_read);
      // R9 soft reset
      wr(6'h10, 32'hFFFFFF83);
      rd(6'h10, "R9 control kept after reset");
      drain();
      sweep("R9 soft reset value");
      // R1 hardware reset mid-run
      wr(6'h14, 32'h55AA55AA);
      wr(6'h00, 32'd7); wr(6'h04, 32'h66);
      @(negedge clk); rst_n = 1'b0; model_reset();
      repeat (2) @(negedge clk);
      check("R11 rdata after mid-run reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      sweep("R1 second hardware reset");
      check("R12 irq at end", {31'h0, irq_o}, 32'h0);
      check("R11 no reads left pending", 32'(exp_q.size()), 32'h0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule